// File: doc/BRIEF.md
# Low-Power Mode Exit Sequencer

This block orders the last steps of a device mode change, the ones that follow regulator and flash power-up. A transition starts with a one-cycle `start` strobe that carries the current mode, the target mode, the set of power domains that the change brings up, and a 16-bit peripheral clock request. The sequencer captures all of these at that edge. It then works through up to three steps:

1. Gate the peripheral clocks.
2. Enable the processor and memory clocks.
3. Ask the processor to leave its halted state.

Each step waits for the completion handshake of the step before it. The pair of modes decides which steps run. A step that does not apply costs no cycle.

When the last applicable step has finished, a single-cycle completion pulse is emitted and the sequencer goes idle again. A power-management controller would drive it: that controller raises `start` once per mode change and watches `trans_done`.

Top module: `lpx_exit_seq`

## Requirements
- R1: Modes are 4-bit codes: Run0..Run3 = 0x4..0x7 (code[3:2] = 2'b01), Halt = 0x8, Stop = 0xA, Standby = 0xD. After a transition is accepted, `periph_clk_en` keeps its value until an edge on which `vreg_done` is or has been sampled high in this transition. From that edge onward, each peripheral outside a starting domain takes its captured request bit.
- R2: Peripheral i belongs to domain i*NDOM/NPER; with the defaults, bits 0..7 are domain 0 and bits 8..15 are domain 1. On the accept edge, the enables of peripherals in domains flagged in `pd_starting` are cleared to 0. They stay 0 until an edge on which both that domain's `pd_done` and the regulator completion have been seen; on that edge they take their request bits.
- R3: `periph_req`, `cur_mode`, `tgt_mode` and `pd_starting` are sampled only on the accept edge. Later changes have no effect on the running transition.
- R4: The processor clock step runs only when the current mode is Halt or Stop and the target is a Run mode. In that case `cpu_clk_en` is cleared on the accept edge. It rises on the first edge, at least one edge after the peripheral step completes, on which `flash_done` is sampled high. In other transitions `cpu_clk_en` keeps its value.
- R5: When the current mode is Halt, Stop or Standby and the target is a Run mode, `cpu_wake` is a one-cycle pulse. It comes one edge after `cpu_clk_en` rises, or one edge after peripheral step completion when leaving Standby. No pulse is given otherwise.
- R6: Steps that do not apply add no cycles. `trans_done` rises on the edge that completes the last applicable step. That edge is the peripheral step completion when only that step applies.
- R7: `trans_done` is high for exactly one cycle per transition, and the next `start` is accepted on the following edge.
- R8: A `start` strobe raised while a transition is in progress is ignored and does not alter its timing or outputs.
- R9: Synchronous active-high reset clears `periph_clk_en`, `cpu_clk_en`, `cpu_wake` and `trans_done` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transition (accepted when idle) |
| cur_mode | input | 4 | Mode being left |
| tgt_mode | input | 4 | Mode being entered |
| vreg_done | input | 1 | Main regulator switch-on finished |
| flash_done | input | 1 | Flash switch-on finished |
| pd_starting | input | NDOM | Domains powered up by this transition |
| pd_done | input | NDOM | Per-domain startup finished |
| periph_req | input | NPER | Requested peripheral clock enables |
| periph_clk_en | output | NPER | Gated peripheral clock enables |
| cpu_clk_en | output | 1 | Processor and system memory clock enable |
| cpu_wake | output | 1 | Processor low-power exit request pulse |
| trans_done | output | 1 | Transition-complete pulse |

## Verification
The bound checker watches these orderings on every cycle:
- a newly set peripheral enable has a regulator completion behind it;
- the processor clock rises only after a sampled flash completion;
- the wake pulse never coincides with the processor clock rising and always coincides with completion;
- both pulses last one cycle.

The exact edge on which each step fires cannot be seen from one cycle of ports alone. It depends on the mode pair and on the arrival order of the regulator, domain and flash handshakes. So the bench sweeps mode pairs, starting-domain sets, handshake delays and busy-time restarts, and computes every expected edge arithmetically.

// File: rtl/lpx_pkg.sv
package lpx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PERIPH,
        ST_CPUCLK,
        ST_WAKE
    } step_e;

    typedef struct packed {
        logic cpu_clk;
        logic wake;
    } plan_t;

    localparam logic [3:0] MODE_HALT = 4'h8;
    localparam logic [3:0] MODE_STOP = 4'hA;
    localparam logic [3:0] MODE_STBY = 4'hD;

    function automatic logic is_run(input logic [3:0] m);
        return m[3:2] == 2'b01;
    endfunction

    function automatic plan_t make_plan(input logic [3:0] cur, input logic [3:0] tgt);
        plan_t p;
        p.cpu_clk = ((cur == MODE_HALT) || (cur == MODE_STOP)) && is_run(tgt);
        p.wake    = ((cur == MODE_HALT) || (cur == MODE_STOP) || (cur == MODE_STBY))
                    && is_run(tgt);
        return p;
    endfunction

    function automatic int dom_of(input int idx, input int nper, input int ndom);
        return (idx * ndom) / nper;
    endfunction

endpackage

// File: rtl/lpx_dom_mask.sv
module lpx_dom_mask #(
    parameter int NPER = 16,
    parameter int NDOM = 2
) (
    input  logic [NDOM-1:0] dom_sel,
    output logic [NPER-1:0] mask
);
    // Expand a per-domain flag vector into a per-peripheral mask.
    for (genvar i = 0; i < NPER; i++) begin : g_bit
        localparam int D = lpx_pkg::dom_of(i, NPER, NDOM);
        assign mask[i] = dom_sel[D];
    end
endmodule

// File: rtl/lpx_step_fsm.sv
module lpx_step_fsm
    import lpx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  plan_t plan_in,
    input  logic  periph_ok,
    input  logic  flash_ok,
    output logic  accept,
    output logic  in_periph,
    output logic  busy,
    output logic  clk_fire,
    output logic  wake_fire,
    output logic  fin
);
    step_e state_q, state_d;
    plan_t plan_q;

    always_comb begin
        state_d   = state_q;
        accept    = 1'b0;
        clk_fire  = 1'b0;
        wake_fire = 1'b0;
        fin       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept = start;
                if (start) state_d = ST_PERIPH;
            end
            ST_PERIPH: begin
                if (periph_ok) begin
                    if (plan_q.cpu_clk)   state_d = ST_CPUCLK;
                    else if (plan_q.wake) state_d = ST_WAKE;
                    else begin
                        fin     = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_CPUCLK: begin
                if (flash_ok) begin
                    clk_fire = 1'b1;
                    if (plan_q.wake) state_d = ST_WAKE;
                    else begin
                        fin     = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_WAKE: begin
                wake_fire = 1'b1;
                fin       = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign in_periph = (state_q == ST_PERIPH);
    assign busy      = (state_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            plan_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) plan_q <= plan_in;
        end
    end
endmodule

// File: rtl/lpx_exit_seq.sv
module lpx_exit_seq
    import lpx_pkg::*;
#(
    parameter int NPER = 16,
    parameter int NDOM = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [3:0]      cur_mode,
    input  logic [3:0]      tgt_mode,
    input  logic            vreg_done,
    input  logic            flash_done,
    input  logic [NDOM-1:0] pd_starting,
    input  logic [NDOM-1:0] pd_done,
    input  logic [NPER-1:0] periph_req,
    output logic [NPER-1:0] periph_clk_en,
    output logic            cpu_clk_en,
    output logic            cpu_wake,
    output logic            trans_done
);
    logic [NPER-1:0] req_q;
    logic [NDOM-1:0] start_dom_q, dom_up_q;
    logic            vreg_seen_q;

    logic            vr, all_up, periph_ok;
    logic [NDOM-1:0] up, avail_dom;
    logic [NPER-1:0] avail_mask, clr_mask;
    plan_t           plan_now;

    logic accept, in_periph, busy, clk_fire, wake_fire, fin;

    assign plan_now  = make_plan(cur_mode, tgt_mode);
    assign vr        = vreg_seen_q | vreg_done;
    assign up        = dom_up_q | pd_done;
    assign avail_dom = ~start_dom_q | up;
    assign all_up    = &avail_dom;
    assign periph_ok = vr & all_up;

    lpx_dom_mask #(.NPER(NPER), .NDOM(NDOM)) u_avail (
        .dom_sel (avail_dom),
        .mask    (avail_mask)
    );

    lpx_dom_mask #(.NPER(NPER), .NDOM(NDOM)) u_clr (
        .dom_sel (pd_starting),
        .mask    (clr_mask)
    );

    lpx_step_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .plan_in   (plan_now),
        .periph_ok (periph_ok),
        .flash_ok  (flash_done),
        .accept    (accept),
        .in_periph (in_periph),
        .busy      (busy),
        .clk_fire  (clk_fire),
        .wake_fire (wake_fire),
        .fin       (fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q         <= '0;
            start_dom_q   <= '0;
            dom_up_q      <= '0;
            vreg_seen_q   <= 1'b0;
            periph_clk_en <= '0;
            cpu_clk_en    <= 1'b0;
            cpu_wake      <= 1'b0;
            trans_done    <= 1'b0;
        end else begin
            cpu_wake   <= wake_fire;
            trans_done <= fin;
            if (accept) begin
                req_q         <= periph_req;
                start_dom_q   <= pd_starting;
                dom_up_q      <= '0;
                vreg_seen_q   <= 1'b0;
                periph_clk_en <= periph_clk_en & ~clr_mask;
                if (plan_now.cpu_clk) cpu_clk_en <= 1'b0;
            end else begin
                if (busy) begin
                    vreg_seen_q <= vr;
                    dom_up_q    <= up;
                end
                if (in_periph && vr) periph_clk_en <= req_q & avail_mask;
                if (clk_fire) cpu_clk_en <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/lpx_exit_chk.sv
module lpx_exit_chk #(
    parameter int NPER = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            vreg_done,
    input logic            flash_done,
    input logic [NPER-1:0] periph_clk_en,
    input logic            cpu_clk_en,
    input logic            cpu_wake,
    input logic            trans_done
);
    logic vseen;

    always_ff @(posedge clk) begin
        if (rst)             vseen <= 1'b0;
        else if (trans_done) vseen <= 1'b0;
        else if (vreg_done)  vseen <= 1'b1;
    end

    // R1: a peripheral enable turning on needs a regulator completion behind it
    a_r1_pclk_after_vreg: assert property (@(posedge clk) disable iff (rst)
        ((periph_clk_en & ~$past(periph_clk_en)) != '0) |-> vseen);

    a_r4_cpuclk_after_flash: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_clk_en) |-> $past(flash_done));

    a_r5_wake_after_clk: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_clk_en) |-> !cpu_wake);

    a_r5_wake_single: assert property (@(posedge clk) disable iff (rst)
        cpu_wake |=> !cpu_wake);

    a_r6_wake_is_last: assert property (@(posedge clk) disable iff (rst)
        cpu_wake |-> trans_done);

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        trans_done |=> !trans_done);
endmodule

bind lpx_exit_seq lpx_exit_chk #(.NPER(NPER)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .vreg_done     (vreg_done),
    .flash_done    (flash_done),
    .periph_clk_en (periph_clk_en),
    .cpu_clk_en    (cpu_clk_en),
    .cpu_wake      (cpu_wake),
    .trans_done    (trans_done)
);

// File: tb/sim_lpx_exit_seq.sv
module sim_lpx_exit_seq;
    localparam int PER = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  cur_mode = 4'h4, tgt_mode = 4'h4;
    logic        vreg_done = 1'b0, flash_done = 1'b0;
    logic [1:0]  pd_starting = '0, pd_done = '0;
    logic [15:0] periph_req = '0;
    logic [15:0] periph_clk_en;
    logic        cpu_clk_en, cpu_wake, trans_done;

    int total = 0, bad = 0;
    logic [15:0] m_pclk = '0;
    logic        m_cpu  = 1'b0;

    always #(PER/2) clk = ~clk;

    lpx_exit_seq u0 (
        .clk(clk), .rst(rst), .start(start), .cur_mode(cur_mode), .tgt_mode(tgt_mode),
        .vreg_done(vreg_done), .flash_done(flash_done), .pd_starting(pd_starting),
        .pd_done(pd_done), .periph_req(periph_req), .periph_clk_en(periph_clk_en),
        .cpu_clk_en(cpu_clk_en), .cpu_wake(cpu_wake), .trans_done(trans_done)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic run(input logic [3:0] cur, input logic [3:0] tgt, input logic [15:0] req,
                       input logic [1:0] sd, input int vd, input int pd0, input int pd1,
                       input int fd, input bit poke);
        bit ac, aw, isrun;
        int p, c, w;
        isrun = (tgt >= 4'h4) && (tgt <= 4'h7);
        ac = ((cur == 4'h8) || (cur == 4'hA)) && isrun;
        aw = ((cur == 4'h8) || (cur == 4'hA) || (cur == 4'hD)) && isrun;
        p = vd;
        if (sd[0]) p = imax(p, pd0);
        if (sd[1]) p = imax(p, pd1);
        c = ac ? imax(p + 1, fd) : p;
        w = aw ? c + 1 : c;

        @(negedge clk);
        start = 1'b1; cur_mode = cur; tgt_mode = tgt; periph_req = req; pd_starting = sd;
        vreg_done = 1'b0; flash_done = 1'b0; pd_done = '0;
        @(posedge clk); #(PER/4);
        for (int i = 0; i < 16; i++) if (sd[i/8]) m_pclk[i] = 1'b0;
        if (ac) m_cpu = 1'b0;
        chk(periph_clk_en == m_pclk, "R2 accept clears starting domains", periph_clk_en, m_pclk);
        chk(cpu_clk_en == m_cpu, "R4 cpu clock at accept", cpu_clk_en, m_cpu);
        chk(trans_done == 1'b0, "R6 no done at accept", trans_done, 0);

        for (int k = 1; k <= w + 1; k++) begin
            @(negedge clk);
            start = poke && (k == 1);          // R8: ignored while busy
            cur_mode = ~cur; tgt_mode = tgt ^ 4'h3;
            periph_req = ~req; pd_starting = ~sd;   // R3: must be ignored
            vreg_done = (k >= vd); flash_done = (k >= fd);
            pd_done[0] = (k >= pd0); pd_done[1] = (k >= pd1);
            @(posedge clk); #(PER/4);
            if (k >= vd && k <= p)
                for (int i = 0; i < 16; i++) begin
                    int dd;
                    dd = (i / 8 == 0) ? pd0 : pd1;
                    if (!sd[i/8] || k >= dd) m_pclk[i] = req[i];
                    else m_pclk[i] = 1'b0;
                end
            if (ac && k == c) m_cpu = 1'b1;
            chk(periph_clk_en == m_pclk, "R1/R2/R3 peripheral enables", periph_clk_en, m_pclk);
            chk(cpu_clk_en == m_cpu, "R4 cpu clock enable", cpu_clk_en, m_cpu);
            chk(cpu_wake == (aw && k == w), "R5 wake pulse", cpu_wake, (aw && k == w));
            chk(trans_done == (k == w), poke ? "R8 done timing with busy start" : "R6/R7 done timing",
                trans_done, (k == w));
        end
        @(negedge clk);
        start = 1'b0; vreg_done = 1'b0; flash_done = 1'b0; pd_done = '0;
        cur_mode = 4'h4; tgt_mode = 4'h4;
    endtask

    initial begin
        #(PER * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [3:0] curs [4];
        logic [3:0] tgts [4];
        curs = '{4'h4, 4'h8, 4'hA, 4'hD};
        tgts = '{4'h5, 4'h7, 4'hA, 4'h8};
        repeat (3) @(posedge clk);
        #(PER/4);
        chk(periph_clk_en == 16'h0, "R9 reset pclk", periph_clk_en, 0);
        chk(cpu_clk_en == 1'b0, "R9 reset cpu clock", cpu_clk_en, 0);
        chk(cpu_wake == 1'b0, "R9 reset wake", cpu_wake, 0);
        chk(trans_done == 1'b0, "R9 reset done", trans_done, 0);
        @(negedge clk); rst = 1'b0;

        for (int ci = 0; ci < 4; ci++)
            for (int ti = 0; ti < 4; ti++)
                for (int sd = 0; sd < 4; sd++) begin
                    logic [15:0] rq;
                    rq = 16'hA5C3 ^ (16'(ci) * 16'h1111) ^ (16'(ti) * 16'h0F0F) ^ 16'(sd);
                    run(curs[ci], tgts[ti], rq, 2'(sd),
                        1 + ((ci + ti + sd) % 3),
                        1 + ((ci * 3 + sd) % 5),
                        1 + ((ti * 2 + sd) % 4),
                        1 + ((ci + ti * 3 + sd) % 5),
                        sd == 2);
                end
        // R7: back-to-back transition accepted right after completion
        run(4'hD, 4'h6, 16'hFFFF, 2'b11, 1, 1, 1, 1, 1'b0);
        run(4'h8, 4'h4, 16'h1234, 2'b00, 1, 1, 1, 1, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule